// File: doc/BRIEF.md
# DRAM Test Command Sequencer

This block replays a short, programmable list of DRAM command slots for memory training and test. Each of the four slots carries a repetition count, a gap count between its own repetitions, an idle count after its last repetition, and a two-bit data-direction code. The engine walks slots 0 up to a programmed last index. It then waits a programmed number of cycles and repeats the whole list for a programmed number of iterations.

The run starts when software writes a non-zero iteration count while the engine is not running. An iteration count of all ones loops forever, and writing zero while running aborts at the next slot boundary. The engine can halt on an error flag from an external data checker and can raise a sticky trigger on the first error. Address generation, data comparison, refresh and the PHY are separate blocks; this one only produces the command-valid strobe, the slot index and the read/write qualifiers.

States: IDLE (after reset), ISSUE (a command is presented), GAP (spacing between repetitions of one slot), PAUSE (idle cycles after a slot's last command), WAIT (spacing after a full pass over the slots), DONE (run finished or aborted) and HALT (stopped on error). Transitions: IDLE/DONE/HALT to ISSUE on start; ISSUE to ISSUE, GAP or PAUSE; GAP to ISSUE; ISSUE or PAUSE at a slot end to ISSUE (next slot or slot 0), WAIT or DONE; WAIT to ISSUE or DONE; any running state to HALT on error with stop enabled.

Top module: `dram_cmd_seq`

## Requirements
- R1: Slots are issued in index order 0, 1, ... up to `last_slot`, where `last_slot` is the index of the final slot used (0 means only slot 0), and each pass restarts at slot 0.
- R2: Each slot issues its command `slot_reps` times per pass; a repetition count of 0 issues the command once.
- R3: Between two repetitions of one slot there are exactly `slot_gap` cycles with no command. After a slot's last command there are `slot_idle` cycles before the next. After each full pass there are `seq_wait` cycles. The busy time of a run is therefore iterations x (sum over used slots of R + (R-1)*gap + idle, plus wait), where R is the effective repetition count.
- R4: `cmd_rd` is high with `cmd_valid` when the slot direction code has bit 0 set (01 read, 11 both). `cmd_wr` is high when bit 1 is set (10 write, 11 both). Code 00 raises neither.
- R5: Writing a non-zero `iter_data` with `iter_wr` while not busy starts a run: the cycle after the write is busy and presents slot 0. `iter_left` decrements after each pass, and the run ends when it reaches 0.
- R6: An iteration count of 8'hFF repeats forever and is never decremented.
- R7: Writing 0 while busy aborts the run after the current slot has issued all its repetitions; `iter_left` becomes 0. Writing a non-zero value while busy has no effect.
- R8: With `stop_on_err` set, `err_in` high in a busy cycle moves the engine to the error state in the next cycle with no further commands. With it clear, the run continues to completion.
- R9: With `trig_en` set, `err_trig` rises the cycle after the first `err_in` of a run and stays high until the next start.
- R10: `status` is one-hot: bit 0 IDLE, bit 1 BUSY, bit 2 DONE, bit 3 ERROR. Reset gives IDLE. BUSY falls in the same cycle DONE or ERROR rises, and a new start clears DONE and ERROR. Commands appear only while BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iter_wr | input | 1 | Write strobe for the iteration count |
| iter_data | input | ITER_W | Iteration count value (0 aborts, all ones repeats forever) |
| last_slot | input | SLOT_W | Index of the last slot in a pass |
| seq_wait | input | WAIT_W | Cycles to wait after each pass |
| stop_on_err | input | 1 | Halt on the first error |
| trig_en | input | 1 | Enable the first-error trigger |
| slot_reps | input | NSLOT x REP_W | Per-slot repetition count |
| slot_gap | input | NSLOT x GAP_W | Per-slot cycles between repetitions |
| slot_idle | input | NSLOT x IDLE_W | Per-slot cycles after the last repetition |
| slot_dir | input | NSLOT x 2 | Per-slot data direction code |
| err_in | input | 1 | Error flag from the data checker |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_slot | output | SLOT_W | Slot index of the issued command |
| cmd_rd | output | 1 | Issued command carries read data |
| cmd_wr | output | 1 | Issued command carries write data |
| status | output | 4 | One-hot IDLE/BUSY/DONE/ERROR |
| iter_left | output | ITER_W | Remaining iterations |
| err_trig | output | 1 | Sticky first-error trigger |

## Verification
The bench goes after a zero repetition count: a design that skips such a slot under-counts commands and ends the run early. It checks the off-by-one edges of gap, idle and wait through exact busy-cycle totals over random configurations; a wrong counter load or terminal value shifts the total by whole cycles per slot. It aborts an infinite run in the middle of a slot and expects the slot to finish, so a design that aborts at once leaves a partial slot, and one that decrements the all-ones count ends the loop on its own. It also checks stop-on-error against a run with the error ignored: a design that keeps issuing after the error, or that halts when it should not, differs in status and command totals.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int DEF_NSLOT  = 4;
    localparam int DEF_REP_W  = 9;
    localparam int DEF_GAP_W  = 5;
    localparam int DEF_IDLE_W = 9;
    localparam int DEF_WAIT_W = 9;
    localparam int DEF_ITER_W = 8;
    localparam int DIR_W      = 2;

    localparam int STAT_IDLE  = 0;
    localparam int STAT_BUSY  = 1;
    localparam int STAT_DONE  = 2;
    localparam int STAT_ERR   = 3;
    localparam int STAT_W     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_PAUSE,
        ST_WAIT,
        ST_DONE,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/dseq_slot_sel.sv
module dseq_slot_sel #(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = 2,
    parameter int REP_W  = 9,
    parameter int GAP_W  = 5,
    parameter int IDLE_W = 9,
    parameter int DIR_W  = 2
) (
    input  logic [SLOT_W-1:0]             sel,
    input  logic [NSLOT-1:0][REP_W-1:0]   reps,
    input  logic [NSLOT-1:0][GAP_W-1:0]   gaps,
    input  logic [NSLOT-1:0][IDLE_W-1:0]  idles,
    input  logic [NSLOT-1:0][DIR_W-1:0]   dirs,
    output logic [REP_W-1:0]              cur_reps,
    output logic [GAP_W-1:0]              cur_gap,
    output logic [IDLE_W-1:0]             cur_idle,
    output logic [DIR_W-1:0]              cur_dir
);

    // Per-slot effective repetition count: zero means a single issue.
    logic [NSLOT-1:0][REP_W-1:0] reps_eff;

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_norm
            assign reps_eff[gi] = (reps[gi] == '0) ? REP_W'(1) : reps[gi];
        end
    endgenerate

    always_comb begin
        cur_reps = reps_eff[sel];
        cur_gap  = gaps[sel];
        cur_idle = idles[sel];
        cur_dir  = dirs[sel];
    end

endmodule

// File: rtl/dseq_timer.sv
module dseq_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == W'(1));

endmodule

// File: rtl/dseq_iter_ctl.sv
module dseq_iter_ctl #(
    parameter int ITER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ITER_W-1:0] wr_data,
    input  logic              active,
    input  logic              dec,
    output logic              start,
    output logic              abort_pend,
    output logic              infinite,
    output logic              last_iter,
    output logic [ITER_W-1:0] iter_q
);

    always_comb begin
        start     = wr && (wr_data != '0) && !active;
        infinite  = (iter_q == '1);
        last_iter = (iter_q <= ITER_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q     <= '0;
            abort_pend <= 1'b0;
        end else if (wr && !active) begin
            iter_q     <= wr_data;
            abort_pend <= 1'b0;
        end else if (wr && active && (wr_data == '0)) begin
            iter_q     <= '0;
            abort_pend <= 1'b1;
        end else if (dec && !infinite && (iter_q != '0)) begin
            iter_q <= iter_q - ITER_W'(1);
        end
    end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dseq_pkg::*;
#(
    parameter int NSLOT  = DEF_NSLOT,
    parameter int REP_W  = DEF_REP_W,
    parameter int GAP_W  = DEF_GAP_W,
    parameter int IDLE_W = DEF_IDLE_W,
    parameter int WAIT_W = DEF_WAIT_W,
    parameter int ITER_W = DEF_ITER_W,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iter_wr,
    input  logic [ITER_W-1:0]             iter_data,
    input  logic [SLOT_W-1:0]             last_slot,
    input  logic [WAIT_W-1:0]             seq_wait,
    input  logic                          stop_on_err,
    input  logic                          trig_en,
    input  logic [NSLOT-1:0][REP_W-1:0]   slot_reps,
    input  logic [NSLOT-1:0][GAP_W-1:0]   slot_gap,
    input  logic [NSLOT-1:0][IDLE_W-1:0]  slot_idle,
    input  logic [NSLOT-1:0][DIR_W-1:0]   slot_dir,
    input  logic                          err_in,
    output logic                          cmd_valid,
    output logic [SLOT_W-1:0]             cmd_slot,
    output logic                          cmd_rd,
    output logic                          cmd_wr,
    output logic [STAT_W-1:0]             status,
    output logic [ITER_W-1:0]             iter_left,
    output logic                          err_trig
);

    localparam int GI_W  = (GAP_W > IDLE_W) ? GAP_W : IDLE_W;
    localparam int CNT_W = (GI_W > WAIT_W) ? GI_W : WAIT_W;

    seq_state_t          state_q, state_d;
    logic [SLOT_W-1:0]   slot_q, slot_d;
    logic [REP_W-1:0]    rep_q, rep_d;

    logic [REP_W-1:0]    cur_reps;
    logic [GAP_W-1:0]    cur_gap;
    logic [IDLE_W-1:0]   cur_idle;
    logic [DIR_W-1:0]    cur_dir;

    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_last;

    logic                start, abort_pend, infinite, last_iter;
    logic                dec_raw, dec;
    logic                active, halt_now, rep_last;
    logic                trig_q;

    // Outcomes at the end of a pass and at the end of a slot
    seq_state_t          it_state, sf_state;
    logic                it_dec, sf_dec, sf_load;
    logic [SLOT_W-1:0]   sf_slot;

    dseq_slot_sel #(
        .NSLOT (NSLOT),
        .SLOT_W(SLOT_W),
        .REP_W (REP_W),
        .GAP_W (GAP_W),
        .IDLE_W(IDLE_W),
        .DIR_W (DIR_W)
    ) u_sel (
        .sel     (slot_q),
        .reps    (slot_reps),
        .gaps    (slot_gap),
        .idles   (slot_idle),
        .dirs    (slot_dir),
        .cur_reps(cur_reps),
        .cur_gap (cur_gap),
        .cur_idle(cur_idle),
        .cur_dir (cur_dir)
    );

    dseq_timer #(
        .W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    dseq_iter_ctl #(
        .ITER_W(ITER_W)
    ) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (iter_wr),
        .wr_data   (iter_data),
        .active    (active),
        .dec       (dec),
        .start     (start),
        .abort_pend(abort_pend),
        .infinite  (infinite),
        .last_iter (last_iter),
        .iter_q    (iter_left)
    );

    always_comb begin
        active = (state_q == ST_ISSUE) || (state_q == ST_GAP) ||
                 (state_q == ST_PAUSE) || (state_q == ST_WAIT);
        halt_now = active && stop_on_err && err_in;
        rep_last = ({1'b0, rep_q} + (REP_W+1)'(1)) >= {1'b0, cur_reps};
    end

    // Decide where a finished pass and a finished slot lead
    always_comb begin
        it_dec   = !infinite;
        it_state = (!infinite && last_iter) ? ST_DONE : ST_ISSUE;

        sf_state = ST_ISSUE;
        sf_slot  = slot_q + SLOT_W'(1);
        sf_load  = 1'b0;
        sf_dec   = 1'b0;
        if (abort_pend) begin
            sf_state = ST_DONE;
            sf_slot  = slot_q;
        end else if (slot_q == last_slot) begin
            sf_slot = '0;
            if (seq_wait != '0) begin
                sf_state = ST_WAIT;
                sf_load  = 1'b1;
            end else begin
                sf_state = it_state;
                sf_dec   = it_dec;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        rep_d    = rep_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        dec_raw  = 1'b0;

        unique case (state_q)
            ST_IDLE, ST_DONE, ST_HALT: begin
                if (start) begin
                    state_d = ST_ISSUE;
                    slot_d  = '0;
                    rep_d   = '0;
                end
            end
            ST_ISSUE: begin
                if (rep_last) begin
                    if (cur_idle != '0) begin
                        state_d  = ST_PAUSE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(cur_idle);
                    end else begin
                        state_d  = sf_state;
                        slot_d   = sf_slot;
                        rep_d    = '0;
                        dec_raw  = sf_dec;
                        tmr_load = sf_load;
                        tmr_val  = CNT_W'(seq_wait);
                    end
                end else begin
                    rep_d = rep_q + REP_W'(1);
                    if (cur_gap != '0) begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(cur_gap);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_last) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_PAUSE: begin
                if (tmr_last) begin
                    state_d  = sf_state;
                    slot_d   = sf_slot;
                    rep_d    = '0;
                    dec_raw  = sf_dec;
                    tmr_load = sf_load;
                    tmr_val  = CNT_W'(seq_wait);
                end
            end
            ST_WAIT: begin
                if (tmr_last) begin
                    slot_d = '0;
                    rep_d  = '0;
                    if (abort_pend) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = it_state;
                        dec_raw = it_dec;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase

        if (halt_now) begin
            state_d = ST_HALT;
        end
        dec = dec_raw && !halt_now;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            rep_q   <= rep_d;
        end
    end

    // Sticky first-error trigger, cleared by a new start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else if (start) begin
            trig_q <= 1'b0;
        end else if (active && err_in && trig_en) begin
            trig_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        status    = '0;
        cmd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  status[STAT_IDLE] = 1'b1;
            ST_DONE:  status[STAT_DONE] = 1'b1;
            ST_HALT:  status[STAT_ERR]  = 1'b1;
            ST_ISSUE: begin
                status[STAT_BUSY] = 1'b1;
                cmd_valid         = 1'b1;
            end
            ST_GAP, ST_PAUSE, ST_WAIT: status[STAT_BUSY] = 1'b1;
            default:  status[STAT_IDLE] = 1'b1;
        endcase
        cmd_slot = cmd_valid ? slot_q : '0;
        cmd_rd   = cmd_valid && cur_dir[0];
        cmd_wr   = cmd_valid && cur_dir[1];
        err_trig = trig_q;
    end

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker
    import dseq_pkg::*;
#(
    parameter int ITER_W = 8,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iter_wr,
    input logic [ITER_W-1:0] iter_data,
    input logic              stop_on_err,
    input logic              err_in,
    input logic              cmd_valid,
    input logic [SLOT_W-1:0] cmd_slot,
    input logic              cmd_rd,
    input logic              cmd_wr,
    input logic [STAT_W-1:0] status,
    input logic [ITER_W-1:0] iter_left,
    input logic              err_trig
);

    assert_status_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(status));

    assert_cmd_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> status[STAT_BUSY]);

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STAT_BUSY]) |-> (status[STAT_DONE] || status[STAT_ERR]));

    assert_dir_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |-> cmd_valid);

    assert_start_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[STAT_BUSY] && iter_wr && (iter_data != '0))
        |=> (status[STAT_BUSY] && cmd_valid && (cmd_slot == '0)));

    assert_infinite_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_BUSY] && (iter_left == '1) && !iter_wr) |=> (iter_left == '1));

    assert_halt_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_BUSY] && stop_on_err && err_in) |=> (status[STAT_ERR] && !cmd_valid));

    assert_trig_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_trig && !(iter_wr && (iter_data != '0) && !status[STAT_BUSY])) |=> err_trig);

endmodule

bind dram_cmd_seq dseq_checker #(
    .ITER_W(ITER_W),
    .SLOT_W(SLOT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iter_wr    (iter_wr),
    .iter_data  (iter_data),
    .stop_on_err(stop_on_err),
    .err_in     (err_in),
    .cmd_valid  (cmd_valid),
    .cmd_slot   (cmd_slot),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .status     (status),
    .iter_left  (iter_left),
    .err_trig   (err_trig)
);

// File: tb/dram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iter_wr = 1'b0;
    logic [7:0]        iter_data = '0;
    logic [1:0]        last_slot = '0;
    logic [8:0]        seq_wait = '0;
    logic              stop_on_err = 1'b0;
    logic              trig_en = 1'b0;
    logic [3:0][8:0]   slot_reps = '0;
    logic [3:0][4:0]   slot_gap = '0;
    logic [3:0][8:0]   slot_idle = '0;
    logic [3:0][1:0]   slot_dir = '0;
    logic              err_in = 1'b0;
    logic              cmd_valid;
    logic [1:0]        cmd_slot;
    logic              cmd_rd, cmd_wr;
    logic [3:0]        status;
    logic [7:0]        iter_left;
    logic              err_trig;

    int errors = 0;
    int checks = 0;
    int m_busy, m_rd, m_wr, m_order_bad, m_first_ok, m_total;
    int m_cnt [4];
    int seed_tmp;

    always #10 clk = ~clk;

    dram_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .iter_wr(iter_wr), .iter_data(iter_data),
        .last_slot(last_slot), .seq_wait(seq_wait), .stop_on_err(stop_on_err),
        .trig_en(trig_en), .slot_reps(slot_reps), .slot_gap(slot_gap),
        .slot_idle(slot_idle), .slot_dir(slot_dir), .err_in(err_in),
        .cmd_valid(cmd_valid), .cmd_slot(cmd_slot), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .status(status), .iter_left(iter_left), .err_trig(err_trig)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_reps(int s);
        return (slot_reps[s] == 0) ? 1 : int'(slot_reps[s]);
    endfunction

    function automatic int exp_busy(int iters);
        int tot;
        tot = 0;
        for (int s = 0; s <= int'(last_slot); s++) begin
            tot += eff_reps(s) + (eff_reps(s) - 1) * int'(slot_gap[s]) + int'(slot_idle[s]);
        end
        tot += int'(seq_wait);
        return tot * iters;
    endfunction

    function automatic int exp_cmds(int s, int iters);
        return (s <= int'(last_slot)) ? eff_reps(s) * iters : 0;
    endfunction

    function automatic int exp_dir(int bitpos, int iters);
        int tot;
        tot = 0;
        for (int s = 0; s <= int'(last_slot); s++) begin
            if (slot_dir[s][bitpos]) tot += eff_reps(s) * iters;
        end
        return tot;
    endfunction

    // Start a run and observe it until BUSY drops
    task automatic run_measure(int iters);
        int prev;
        @(negedge clk);
        iter_wr = 1'b1;
        iter_data = 8'(iters);
        @(negedge clk);
        iter_wr = 1'b0;
        m_first_ok = (status == 4'b0010 && cmd_valid && cmd_slot == 2'd0) ? 1 : 0;
        m_busy = 0; m_rd = 0; m_wr = 0; m_order_bad = 0; prev = -1;
        for (int s = 0; s < 4; s++) m_cnt[s] = 0;
        for (int g = 0; g < 20000 && status[1]; g++) begin
            m_busy++;
            if (cmd_valid) begin
                m_cnt[cmd_slot]++;
                if (cmd_rd) m_rd++;
                if (cmd_wr) m_wr++;
                if (prev >= 0 && !(int'(cmd_slot) == prev || int'(cmd_slot) == prev + 1 ||
                    (cmd_slot == 2'd0 && prev == int'(last_slot)))) m_order_bad++;
                prev = int'(cmd_slot);
            end
            @(negedge clk);
        end
    endtask

    task automatic check_run(string name, int iters);
        run_measure(iters);
        check_eq({name, " R5 first cycle busy at slot 0"}, m_first_ok, 1);
        check_eq({name, " R1 slot order"}, m_order_bad, 0);
        for (int s = 0; s < 4; s++)
            check_eq($sformatf("%s R2 slot %0d commands", name, s), m_cnt[s], exp_cmds(s, iters));
        check_eq({name, " R3 busy cycles"}, m_busy, exp_busy(iters));
        check_eq({name, " R4 read commands"}, m_rd, exp_dir(0, iters));
        check_eq({name, " R4 write commands"}, m_wr, exp_dir(1, iters));
        check_eq({name, " R10 DONE status"}, int'(status), 4'b0100);
        check_eq({name, " R5 iter_left zero"}, int'(iter_left), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        seed_tmp = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check_eq("R10 reset status IDLE", int'(status), 4'b0001);
        check_eq("R10 reset no command", int'(cmd_valid), 0);
        check_eq("R9 reset trigger low", int'(err_trig), 0);

        // R2: zero repetition counts issue once each
        last_slot = 2'd3;
        slot_dir = {2'd3, 2'd2, 2'd1, 2'd0};
        check_run("zero-reps", 2);

        // R1/R3: single slot with gaps
        last_slot = 2'd0;
        slot_reps[0] = 9'd3;
        slot_gap[0] = 5'd2;
        check_run("single-slot", 1);

        // Random configurations
        for (int t = 0; t < 10; t++) begin
            for (int s = 0; s < 4; s++) begin
                slot_reps[s] = 9'($urandom_range(5, 0));
                slot_gap[s]  = 5'($urandom_range(3, 0));
                slot_idle[s] = 9'($urandom_range(3, 0));
                slot_dir[s]  = 2'($urandom_range(3, 0));
            end
            last_slot = 2'($urandom_range(3, 0));
            seq_wait  = 9'($urandom_range(4, 0));
            stop_on_err = 1'($urandom_range(1, 0));
            check_run($sformatf("random%0d", t), int'($urandom_range(3, 1)));
        end

        // R6/R7: infinite run, ignored write, abort mid-slot
        stop_on_err = 1'b0;
        last_slot = 2'd0;
        slot_reps = '0; slot_gap = '0; slot_idle = '0; slot_dir = '0;
        slot_reps[0] = 9'd4;
        seq_wait = 9'd2;
        @(negedge clk);
        iter_wr = 1'b1; iter_data = 8'hFF;
        @(negedge clk);
        iter_wr = 1'b0;
        m_busy = 0; m_total = 0;
        for (int g = 0; g < 20000 && status[1]; g++) begin
            m_busy++;
            if (cmd_valid) m_total++;
            if (m_busy == 20) begin iter_wr = 1'b1; iter_data = 8'd5; end
            if (m_busy == 21) begin
                iter_wr = 1'b0;
                check_eq("R7 non-zero write while busy ignored", int'(iter_left), 255);
            end
            if (m_busy == 30) check_eq("R6 infinite count not decremented", int'(iter_left), 255);
            if (m_busy == 38) begin iter_wr = 1'b1; iter_data = 8'd0; end
            if (m_busy == 39) iter_wr = 1'b0;
            @(negedge clk);
        end
        check_eq("R7 abort finishes current slot commands", m_total, 28);
        check_eq("R7 abort busy cycles", m_busy, 40);
        check_eq("R7 abort gives DONE", int'(status), 4'b0100);
        check_eq("R7 abort clears iter_left", int'(iter_left), 0);

        // R8/R9: stop on error
        seq_wait = 9'd0;
        slot_reps[0] = 9'd10;
        stop_on_err = 1'b1;
        trig_en = 1'b1;
        @(negedge clk);
        iter_wr = 1'b1; iter_data = 8'd1;
        @(negedge clk);
        iter_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
        check_eq("R8 halt status ERROR", int'(status), 4'b1000);
        check_eq("R8 no command after halt", int'(cmd_valid), 0);
        check_eq("R9 trigger raised", int'(err_trig), 1);
        repeat (5) @(negedge clk);
        check_eq("R8 ERROR held", int'(status), 4'b1000);
        check_eq("R9 trigger sticky", int'(err_trig), 1);

        // R10 new start clears ERROR and trigger; R8 no stop continues
        stop_on_err = 1'b0;
        iter_wr = 1'b1; iter_data = 8'd1;
        @(negedge clk);
        iter_wr = 1'b0;
        check_eq("R10 restart clears ERROR", int'(status), 4'b0010);
        check_eq("R9 restart clears trigger", int'(err_trig), 0);
        m_total = 1;
        @(negedge clk);
        err_in = 1'b1;
        if (cmd_valid) m_total++;
        @(negedge clk);
        err_in = 1'b0;
        check_eq("R8 error ignored without stop", int'(status), 4'b0010);
        check_eq("R9 trigger on error without stop", int'(err_trig), 1);
        for (int g = 0; g < 200 && status[1]; g++) begin
            if (cmd_valid) m_total++;
            @(negedge clk);
        end
        check_eq("R8 full command count without stop", m_total, 10);
        check_eq("R10 DONE after run", int'(status), 4'b0100);

        summary();
        $finish;
    end

endmodule